// File: doc/BRIEF.md
# Byte Stream Toy Processor

A small sequential processor that executes a fixed program of byte instructions. It holds eight one-byte general registers, a program counter that counts instruction positions, and a 256-byte data store that reset clears to zero. Each instruction finishes in one clock cycle. The two exceptions are the stream instructions, which wait until their valid/ready handshake completes. Additions pass through an 8-bit ripple chain of one-bit full adders.

The instruction store is a bank of flops. Reset loads it with the `PROG_INIT` parameter, whose default is an echo program: it reads bytes until a newline or until 60 bytes have arrived, adds 3 to each stored byte, and streams the results out. A preload port can overwrite single words. While that port is writing, the core is frozen. This lets a program be loaded right after reset and run from instruction 0 once the port goes quiet.

Top module: `byte_cpu`

## Requirements
- R1: Asynchronous reset sets every register and every data-memory byte to zero, sets pc to 0 and clears halted_o. During reset in_ready_o and out_valid_o are low.
- R2: An instruction is 18 bits. Bits [17:14] are the opcode, [13:11] are field A, [10:8] are field B and [7:0] are the immediate or target. The opcodes are: 0 set, 1 add, 2 load, 3 store, 4 branch-if-equal, 5 branch-if-below, 6 read, 7 write.
- R3: Opcode 0 writes the immediate into register A. Opcode 1 writes (A + B) mod 256 into register A.
- R4: Opcode 2 writes memory[B] into register A. Opcode 3 writes register B to memory[A].
- R5: Opcode 4 sets pc to the target when registers A and B are equal. Otherwise pc advances by one.
- R6: Opcode 5 sets pc to the target when register A is below register B, comparing as unsigned bytes. Otherwise pc advances by one.
- R7: Opcode 6 raises in_ready_o. When in_valid_i is high, it loads in_data_i into register A and advances. When in_valid_i is low, no state changes.
- R8: Opcode 7 raises out_valid_o with register A on out_data_o. The instruction advances only when out_ready_i is high, and the data holds steady while it waits.
- R9: Opcodes 8 to 15 set halted_o. halted_o then stays high until reset, and no further handshake is offered.
- R10: When the next pc would be PROG_DEPTH or beyond, the processor halts instead of moving pc.
- R11: While prog_we_i is high, prog_data_i is written to slot prog_addr_i. During that cycle the core makes no state change and offers no handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prog_we_i | input | 1 | Instruction preload write enable; freezes the core |
| prog_addr_i | input | 8 | Preload slot index |
| prog_data_i | input | 18 | Preload instruction word |
| in_data_i | input | 8 | Input stream byte |
| in_valid_i | input | 1 | Input byte available |
| in_ready_o | output | 1 | Read instruction waiting for a byte |
| out_data_o | output | 8 | Output stream byte |
| out_valid_o | output | 1 | Write instruction offering a byte |
| out_ready_i | input | 1 | Sink accepts the byte |
| halted_o | output | 1 | Processor has stopped |

## Verification
Five properties are checked on every cycle. Once halted_o is high it stays high. A read with no valid byte leaves pc and the ready signal unchanged. A write refused by the sink keeps its data steady. A preload cycle freezes pc. While running, pc stays inside the program. Arithmetic wrap, unsigned comparison, memory contents, the zero memory after reset and the exact byte sequence only show up across whole programs. The bench therefore runs the echo program on random and edge-case input and a directed branch/memory program, and compares every emitted byte with a model.

// File: rtl/byte_cpu_pkg.sv
package byte_cpu_pkg;
  localparam int DW     = 8;
  localparam int RA_W   = 3;
  localparam int INSN_W = 18;
  localparam int PC_W   = 8;
  localparam int DEMO_DEPTH = 32;

  typedef enum logic [3:0] {
    OP_SET   = 4'd0,
    OP_ADD   = 4'd1,
    OP_LOAD  = 4'd2,
    OP_STORE = 4'd3,
    OP_BEQ   = 4'd4,
    OP_BLT   = 4'd5,
    OP_READ  = 4'd6,
    OP_WRITE = 4'd7,
    OP_STOP  = 4'd15
  } opcode_e;

  typedef struct packed {
    opcode_e         op;
    logic [RA_W-1:0] fa;
    logic [RA_W-1:0] fb;
    logic [DW-1:0]   imm;
  } insn_t;

  function automatic logic [INSN_W-1:0] mk(opcode_e op, int a, int b, int imm);
    return {op, a[RA_W-1:0], b[RA_W-1:0], imm[DW-1:0]};
  endfunction

  // echo-plus-three program: r0 count, r1 index, r2 limit/addr, r3 const, r5 one
  function automatic logic [DEMO_DEPTH*INSN_W-1:0] demo_prog();
    logic [INSN_W-1:0] p [DEMO_DEPTH];
    logic [DEMO_DEPTH*INSN_W-1:0] flat;
    for (int i = 0; i < DEMO_DEPTH; i++) p[i] = mk(OP_STOP, 0, 0, 0);
    p[0]  = mk(OP_SET, 0, 0, 0);
    p[1]  = mk(OP_SET, 1, 0, 0);
    p[2]  = mk(OP_SET, 2, 0, 60);
    p[3]  = mk(OP_SET, 3, 0, 10);
    p[4]  = mk(OP_SET, 5, 0, 1);
    p[5]  = mk(OP_READ, 4, 0, 0);
    p[6]  = mk(OP_STORE, 1, 4, 0);
    p[7]  = mk(OP_BEQ, 4, 3, 11);
    p[8]  = mk(OP_ADD, 0, 5, 0);
    p[9]  = mk(OP_ADD, 1, 5, 0);
    p[10] = mk(OP_BLT, 0, 2, 5);
    p[11] = mk(OP_SET, 1, 0, 0);
    p[12] = mk(OP_SET, 3, 0, 3);
    p[13] = mk(OP_LOAD, 4, 1, 0);
    p[14] = mk(OP_ADD, 4, 3, 0);
    p[15] = mk(OP_SET, 2, 0, 64);
    p[16] = mk(OP_ADD, 2, 1, 0);
    p[17] = mk(OP_STORE, 2, 4, 0);
    p[18] = mk(OP_ADD, 1, 5, 0);
    p[19] = mk(OP_BLT, 1, 0, 13);
    p[20] = mk(OP_SET, 1, 0, 0);
    p[21] = mk(OP_SET, 2, 0, 64);
    p[22] = mk(OP_ADD, 2, 1, 0);
    p[23] = mk(OP_LOAD, 2, 2, 0);
    p[24] = mk(OP_WRITE, 2, 0, 0);
    p[25] = mk(OP_ADD, 1, 5, 0);
    p[26] = mk(OP_BLT, 1, 0, 21);
    for (int i = 0; i < DEMO_DEPTH; i++) flat[i*INSN_W +: INSN_W] = p[i];
    return flat;
  endfunction
endpackage

// File: rtl/bc_prog_rom.sv
module bc_prog_rom
  import byte_cpu_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter logic [DEPTH*INSN_W-1:0] INIT = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PC_W-1:0]   waddr_i,
  input  logic [INSN_W-1:0] wdata_i,
  input  logic [PC_W-1:0]   raddr_i,
  output insn_t             rdata_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PC_W:0] LIM = (PC_W+1)'(DEPTH);

  logic [INSN_W-1:0] slot_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= INIT[i*INSN_W +: INSN_W];
    end else if (we_i && ({1'b0, waddr_i} < LIM)) begin
      slot_q[waddr_i[AW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    if ({1'b0, raddr_i} < LIM) rdata_o = insn_t'(slot_q[raddr_i[AW-1:0]]);
    else                       rdata_o = insn_t'({OP_STOP, {(INSN_W-4){1'b0}}});
  end
endmodule

// File: rtl/bc_regfile.sv
module bc_regfile
  import byte_cpu_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RA_W-1:0] wsel_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic [RA_W-1:0] asel_i,
  output logic [DW-1:0]   adata_o,
  input  logic [RA_W-1:0] bsel_i,
  output logic [DW-1:0]   bdata_o
);
  logic [DW-1:0] r_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) r_q[i] <= '0;
    end else if (we_i) begin
      r_q[wsel_i] <= wdata_i;
    end
  end

  assign adata_o = r_q[asel_i];
  assign bdata_o = r_q[bsel_i];
endmodule

// File: rtl/bc_dmem.sv
module bc_dmem
  import byte_cpu_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] m_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) m_q[i] <= '0;
    end else if (we_i) begin
      m_q[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = m_q[addr_i];
endmodule

// File: rtl/bc_ripple_add.sv
module bc_ripple_add #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o
);
  logic [W-1:0] c;
  assign c[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_o[i] = a_i[i] ^ b_i[i] ^ c[i];
    if (i < W-1) begin : g_carry
      assign c[i+1] = (a_i[i] & b_i[i]) | (c[i] & (a_i[i] ^ b_i[i]));
    end
  end
endmodule

// File: rtl/byte_cpu.sv
module byte_cpu
  import byte_cpu_pkg::*;
#(
  parameter int PROG_DEPTH = DEMO_DEPTH,
  parameter logic [PROG_DEPTH*INSN_W-1:0] PROG_INIT = demo_prog(),
  parameter int NREG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_we_i,
  input  logic [PC_W-1:0]   prog_addr_i,
  input  logic [INSN_W-1:0] prog_data_i,
  input  logic [DW-1:0]     in_data_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  output logic [DW-1:0]     out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              halted_o
);
  localparam logic [PC_W:0] PC_LIM = (PC_W+1)'(PROG_DEPTH);

  logic [PC_W-1:0] pc_q;
  logic            halted_q;
  insn_t           insn;
  logic [DW-1:0]   a_val, b_val, sum, mem_rd, rf_wd, mem_addr;
  logic            rf_we, mem_we, adv, jump, stop_req, running;
  logic [PC_W:0]   pc_inc, pc_nxt;
  logic            past_end;

  bc_prog_rom #(.DEPTH(PROG_DEPTH), .INIT(PROG_INIT)) i_rom (
    .clk_i, .rst_ni,
    .we_i(prog_we_i), .waddr_i(prog_addr_i), .wdata_i(prog_data_i),
    .raddr_i(pc_q), .rdata_o(insn)
  );

  bc_regfile #(.NREG(NREG)) i_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .wsel_i(insn.fa), .wdata_i(rf_wd),
    .asel_i(insn.fa), .adata_o(a_val),
    .bsel_i(insn.fb), .bdata_o(b_val)
  );

  assign mem_addr = (insn.op == OP_STORE) ? a_val : b_val;

  bc_dmem #(.AW(DW)) i_mem (
    .clk_i, .rst_ni,
    .we_i(mem_we), .addr_i(mem_addr), .wdata_i(b_val), .rdata_o(mem_rd)
  );

  bc_ripple_add #(.W(DW)) i_add (.a_i(a_val), .b_i(b_val), .sum_o(sum));

  assign running = !halted_q && !prog_we_i;

  always_comb begin
    rf_we    = 1'b0;
    rf_wd    = insn.imm;
    mem_we   = 1'b0;
    adv      = 1'b0;
    jump     = 1'b0;
    stop_req = 1'b0;
    if (running) begin
      case (insn.op)
        OP_SET:   begin rf_we = 1'b1; adv = 1'b1; end
        OP_ADD:   begin rf_we = 1'b1; rf_wd = sum; adv = 1'b1; end
        OP_LOAD:  begin rf_we = 1'b1; rf_wd = mem_rd; adv = 1'b1; end
        OP_STORE: begin mem_we = 1'b1; adv = 1'b1; end
        OP_BEQ:   begin adv = 1'b1; jump = (a_val == b_val); end
        OP_BLT:   begin adv = 1'b1; jump = (a_val < b_val); end
        OP_READ:  begin
          if (in_valid_i) begin rf_we = 1'b1; rf_wd = in_data_i; adv = 1'b1; end
        end
        OP_WRITE: adv = out_ready_i;
        default:  stop_req = 1'b1;
      endcase
    end
  end

  assign pc_inc   = {1'b0, pc_q} + (PC_W+1)'(1);
  assign pc_nxt   = jump ? {1'b0, insn.imm} : pc_inc;
  assign past_end = adv && (pc_nxt >= PC_LIM);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (stop_req || past_end) begin
      halted_q <= 1'b1;
    end else if (adv) begin
      pc_q <= pc_nxt[PC_W-1:0];
    end
  end

  assign in_ready_o  = running && (insn.op == OP_READ);
  assign out_valid_o = running && (insn.op == OP_WRITE);
  assign out_data_o  = a_val;
  assign halted_o    = halted_q;

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> halted_o);

  p_read_wait_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i && !prog_we_i) |=> ($stable(pc_q) && in_ready_o));

  p_write_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !prog_we_i) |=> (out_valid_o && $stable(out_data_o)));

  p_preload_freeze_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_we_i |=> $stable(pc_q));

  p_pc_in_prog_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halted_o |-> ({1'b0, pc_q} < PC_LIM));
endmodule

// File: tb/test_byte_cpu.sv
module test_byte_cpu;
  import byte_cpu_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic prog_we = 1'b0;
  logic [7:0] prog_addr = '0;
  logic [17:0] prog_data = '0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, halted;
  logic [7:0] out_data;

  always #5 clk = ~clk;

  byte_cpu i_byte_cpu (
    .clk_i(clk), .rst_ni(rst_ni),
    .prog_we_i(prog_we), .prog_addr_i(prog_addr), .prog_data_i(prog_data),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .halted_o(halted)
  );

  int n_tests = 0, n_fail = 0;
  logic [17:0] prog [32];
  logic [7:0] in_buf [64];
  int in_n, in_idx;
  logic [7:0] got [64];
  int got_n;

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [17:0] enc(int op, int a, int b, int imm);
    return {op[3:0], a[2:0], b[2:0], imm[7:0]};
  endfunction

  task automatic start(bit load);
    prog_we = load; in_valid = 0; out_ready = 0; rst_ni = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    if (load) begin
      for (int i = 0; i < 32; i++) begin
        @(negedge clk);
        prog_addr = 8'(i); prog_data = prog[i];
      end
      repeat (8) @(negedge clk);
      check(!in_ready && !out_valid && !halted, "R11 frozen during preload", in_ready, 0);
      prog_we = 0;
    end
    in_idx = 0; got_n = 0;
  endtask

  task automatic run(int max_cyc, int gap);
    for (int c = 0; c < max_cyc && !halted; c++) begin
      @(negedge clk);
      in_valid  = (in_idx < in_n) && (($urandom % 100) >= gap);
      in_data   = in_buf[in_idx % 64];
      out_ready = ($urandom % 100) >= gap;
      #1;
      if (in_valid && in_ready) in_idx++;
      if (out_valid && out_ready && got_n < 64) begin
        got[got_n] = out_data; got_n++;
      end
    end
    in_valid = 0;
  endtask

  task automatic check_echo(string tag);
    int len, n_exp, used;
    len = 0;
    for (int i = 0; i < 60; i++) begin
      if (in_buf[i] == 8'd10) break;
      len++;
    end
    n_exp = (len == 0) ? 1 : len;
    used  = (len < 60) ? len + 1 : 60;
    check(got_n == n_exp, "R8 output count", got_n, n_exp);
    check(in_idx == used, "R7 bytes consumed", in_idx, used);
    for (int k = 0; k < n_exp && k < got_n; k++)
      check(got[k] == 8'(in_buf[k] + 8'd3), "R3 R4 echo byte", got[k], 8'(in_buf[k] + 8'd3));
    check(halted, "R9 halts at stop opcode", halted, 1);
    if (tag.len() == 0) $display("unreachable");
  endtask

  function automatic logic [7:0] rnd_byte();
    logic [7:0] b;
    do b = 8'($urandom); while (b == 8'd10);
    return b;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));

    // R1: state during reset
    @(negedge clk);
    check(!halted && !in_ready && !out_valid, "R1 reset outputs", {halted, in_ready, out_valid}, 0);

    // default program, directed line with wrap byte, R7 long wait first
    start(0);
    in_buf[0] = "h"; in_buf[1] = 8'd255; in_buf[2] = "y"; in_buf[3] = 8'd10; in_n = 4;
    repeat (25) @(negedge clk);
    check(in_ready && !out_valid && !halted, "R7 waits for input", in_ready, 1);
    run(5000, 30);
    check_echo("line");

    // 60 bytes, no newline
    start(0);
    for (int i = 0; i < 64; i++) in_buf[i] = rnd_byte();
    in_n = 64;
    run(20000, 20);
    check_echo("full");

    // empty line
    start(0);
    in_buf[0] = 8'd10; in_n = 1;
    run(2000, 0);
    check_echo("empty");

    // random lines
    for (int t = 0; t < 6; t++) begin
      int l;
      start(0);
      l = int'($urandom % 60);
      for (int i = 0; i < 64; i++) in_buf[i] = rnd_byte();
      in_buf[l] = 8'd10; in_n = l + 1;
      run(20000, 40);
      check_echo("rand");
    end

    // directed branch / memory program, preloaded
    for (int i = 0; i < 32; i++) prog[i] = enc(15, 0, 0, 0);
    prog[0]  = enc(0, 1, 0, 200);
    prog[1]  = enc(0, 2, 0, 5);
    prog[2]  = enc(5, 1, 2, 4);
    prog[3]  = enc(7, 1, 0, 0);
    prog[4]  = enc(5, 2, 1, 6);
    prog[5]  = enc(7, 2, 0, 0);
    prog[6]  = enc(4, 1, 2, 8);
    prog[7]  = enc(7, 2, 0, 0);
    prog[8]  = enc(4, 1, 1, 10);
    prog[9]  = enc(7, 1, 0, 0);
    prog[10] = enc(0, 3, 0, 250);
    prog[11] = enc(0, 4, 0, 10);
    prog[12] = enc(1, 3, 4, 0);
    prog[13] = enc(7, 3, 0, 0);
    prog[14] = enc(0, 5, 0, 77);
    prog[15] = enc(3, 4, 5, 0);
    prog[16] = enc(2, 6, 4, 0);
    prog[17] = enc(7, 6, 0, 0);
    prog[18] = enc(0, 0, 0, 200);
    prog[19] = enc(2, 7, 0, 0);
    prog[20] = enc(7, 7, 0, 0);
    prog[21] = enc(9, 0, 0, 0);
    prog[22] = enc(7, 1, 0, 0);
    start(1);
    in_n = 0;
    repeat (15) @(negedge clk);
    check(out_valid && out_data == 8'd200, "R8 holds while sink busy", out_data, 200);
    run(500, 0);
    check(got_n == 5, "R5 R6 output count", got_n, 5);
    check(got[0] == 8'd200, "R6 unsigned not-below", got[0], 200);
    check(got[1] == 8'd5,   "R5 R6 taken/not-taken", got[1], 5);
    check(got[2] == 8'd4,   "R3 add wraps", got[2], 4);
    check(got[3] == 8'd77,  "R4 store then load", got[3], 77);
    check(got[4] == 8'd0,   "R1 memory cleared", got[4], 0);
    out_ready = 1;
    repeat (6) @(negedge clk);
    check(halted && !out_valid && !in_ready, "R9 unused opcode halts quietly", halted, 1);

    // R10: run past last slot; R1 memory cleared again by reset
    for (int i = 0; i < 32; i++) prog[i] = enc(0, 2, 0, 1);
    prog[0]  = enc(0, 0, 0, 10);
    prog[1]  = enc(2, 1, 0, 0);
    prog[2]  = enc(7, 1, 0, 0);
    prog[31] = enc(7, 0, 0, 0);
    start(1);
    run(500, 10);
    check(got_n == 2, "R10 output count", got_n, 2);
    check(got[0] == 8'd0, "R1 reset cleared mem[10]", got[0], 0);
    check(got[1] == 8'd10, "R2 R10 last slot runs", got[1], 10);
    check(halted, "R10 halts past last instruction", halted, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule